// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Core

This block is a synthesizable behavioural model of a synchronous SRAM with a common data bus, in which every command moves exactly two bus-width beats. It runs on one clock at beat rate, twice the command rate, so each clock cycle is one beat. A command is presented with a load strobe, a direction select and a pair address. The pair address has one bit fewer than a beat-granular address because each array entry holds two beats side by side. The even beat is the low half of the entry and the odd beat is the high half.

Writes are gathered beat by beat, each beat with its own nine-bit byte-lane enables. The completed two-beat word waits in a late-write buffer and is merged into the array only when the next write completes. Reads fetch one full entry, merge in any matching buffered bytes, and present the two halves on consecutive beats after a fixed latency. A read-valid flag and a beat-phase flag travel with the data. The data bus is split into an input, an output and an output enable, which the pad ring joins into one bidirectional line.

Top module: `b2_ddr_sram`

## Requirements
- R1: After reset, `rd_valid`, `dq_oe` and `rd_beat` are low and `dq_o` is zero.
- R2: A read accepted on clock edge C drives its even beat after edge C+RD_LAT and its odd beat after edge C+RD_LAT+1, with `rd_valid` high for exactly those two cycles (RD_LAT defaults to 4 beats, i.e. 2.0 command clocks).
- R3: A write accepted on edge C takes `dq_i` sampled on edge C+1 as the even half (bits BUS_W-1:0 of the entry) and `dq_i` sampled on edge C+2 as the odd half (bits 2*BUS_W-1:BUS_W). A later read returns both halves in that order.
- R4: Byte enable k of a beat gates bus bits 9k to 9k+8 of that beat; lanes whose enable is low keep their previous contents.
- R5: A read of an address whose write still sits in the late-write buffer returns the buffered bytes merged over the array contents.
- R6: A load strobe in the cycle right after an accepted command is ignored: it neither produces read beats nor changes the array.
- R7: A read accepted before a write to the same address returns the data held before that write, even when the write is accepted two cycles later.
- R8: `dq_oe` is high only in cycles where `rd_valid` is high, and `rd_beat` is 0 on the even beat and 1 on the odd beat.
- R9: Reads accepted every two cycles produce an unbroken stream of read beats, even/odd alternating, in command order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock, two cycles per command slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ld | input | 1 | Load strobe, starts a command when the block is free |
| cmd_wr | input | 1 | Direction select: 1 write, 0 read |
| cmd_addr | input | AW | Pair address of the two-beat entry |
| bw_en | input | BUS_W/9 | Per-lane write enables of the beat on `dq_i` |
| dq_i | input | BUS_W | Write data beat from the bus |
| dq_o | output | BUS_W | Read data beat to the bus |
| dq_oe | output | 1 | Bus output enable, high only during read beats |
| rd_valid | output | 1 | Read beat valid |
| rd_beat | output | 1 | Phase of the beat on `dq_o`: 0 even, 1 odd |

## Verification
The case that matters is a read output and a write landing in the same cycle. A read is issued and a write to the same pair address is accepted two cycles later, so the write's second beat arrives as the read's first beat leaves. The read must carry the old data and a later read the new data. A second collision places a read onto an address whose write is still in the late-write buffer, first with all lanes enabled and then with a partial lane mask. Each beat is compared with a lane-by-lane reference model kept in the bench.

// File: rtl/b2_sram_pkg.sv
package b2_sram_pkg;
   localparam int unsigned LANE_BITS = 9;

   typedef enum logic {
      BEAT_EVEN = 1'b0,
      BEAT_ODD  = 1'b1
   } beat_e;
endpackage

// File: rtl/b2_cmd_ctl.sv
module b2_cmd_ctl #(
   parameter int unsigned AW     = 5,
   parameter int unsigned RD_LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_ld,
   input  logic          cmd_wr,
   input  logic [AW-1:0] cmd_addr,
   output logic          cmd_acc,
   output logic          wr_even_cap,
   output logic          wr_odd_cap,
   output logic [AW-1:0] wr_addr,
   output logic          rd_fire,
   output logic [AW-1:0] rd_addr
);
   logic          slot_busy;
   logic          even_q, odd_q;
   logic [AW-1:0] wa_even, wa_odd;
   logic [RD_LAT-1:0] rd_v;
   logic [AW-1:0]     rd_a [RD_LAT];

   assign cmd_acc = cmd_ld && !slot_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_busy <= 1'b0;
         even_q    <= 1'b0;
         odd_q     <= 1'b0;
         wa_even   <= '0;
         wa_odd    <= '0;
      end else begin
         slot_busy <= cmd_acc;
         even_q    <= cmd_acc && cmd_wr;
         odd_q     <= even_q;
         if (cmd_acc && cmd_wr) wa_even <= cmd_addr;
         if (even_q)            wa_odd  <= wa_even;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_v <= '0;
         for (int i = 0; i < RD_LAT; i++) rd_a[i] <= '0;
      end else begin
         rd_v[0] <= cmd_acc && !cmd_wr;
         rd_a[0] <= cmd_addr;
         for (int i = 1; i < RD_LAT; i++) begin
            rd_v[i] <= rd_v[i-1];
            rd_a[i] <= rd_a[i-1];
         end
      end
   end

   assign wr_even_cap = even_q;
   assign wr_odd_cap  = odd_q;
   assign wr_addr     = wa_odd;
   assign rd_fire     = rd_v[RD_LAT-1];
   assign rd_addr     = rd_a[RD_LAT-1];
endmodule

// File: rtl/b2_wr_gather.sv
module b2_wr_gather
   import b2_sram_pkg::*;
#(
   parameter int unsigned BUS_W = 18,
   parameter int unsigned AW    = 5,
   localparam int unsigned LANES = BUS_W / LANE_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               even_cap,
   input  logic               odd_cap,
   input  logic [AW-1:0]      wr_addr,
   input  logic [BUS_W-1:0]   dq_i,
   input  logic [LANES-1:0]   bw_en,
   output logic               buf_vld,
   output logic [AW-1:0]      buf_addr,
   output logic [2*BUS_W-1:0] buf_data,
   output logic [2*LANES-1:0] buf_lanes,
   output logic               commit
);
   logic [BUS_W-1:0] even_d;
   logic [LANES-1:0] even_m;

   // the previous buffered write drains into the array on the edge that fills the buffer again
   assign commit = odd_cap && buf_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         even_d    <= '0;
         even_m    <= '0;
         buf_vld   <= 1'b0;
         buf_addr  <= '0;
         buf_data  <= '0;
         buf_lanes <= '0;
      end else begin
         if (even_cap) begin
            even_d <= dq_i;
            even_m <= bw_en;
         end
         if (odd_cap) begin
            buf_vld   <= 1'b1;
            buf_addr  <= wr_addr;
            buf_data  <= {dq_i, even_d};
            buf_lanes <= {bw_en, even_m};
         end
      end
   end
endmodule

// File: rtl/b2_array.sv
module b2_array
   import b2_sram_pkg::*;
#(
   parameter int unsigned BUS_W = 18,
   parameter int unsigned AW    = 5,
   localparam int unsigned LANES = BUS_W / LANE_BITS,
   localparam int unsigned WW    = 2 * BUS_W,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic               clk,
   input  logic               commit,
   input  logic               buf_vld,
   input  logic [AW-1:0]      buf_addr,
   input  logic [WW-1:0]      buf_data,
   input  logic [2*LANES-1:0] buf_lanes,
   input  logic [AW-1:0]      rd_addr,
   output logic [WW-1:0]      rd_word
);
   logic [WW-1:0] mem [DEPTH];
   logic [WW-1:0] bit_mask;
   logic [WW-1:0] cur_wr, cur_rd;
   logic          fwd_hit;

   for (genvar j = 0; j < 2 * LANES; j++) begin : g_lane_mask
      assign bit_mask[j*LANE_BITS +: LANE_BITS] = {LANE_BITS{buf_lanes[j]}};
   end

   assign cur_wr  = mem[buf_addr];
   assign cur_rd  = mem[rd_addr];
   assign fwd_hit = buf_vld && (buf_addr == rd_addr);
   assign rd_word = fwd_hit ? ((cur_rd & ~bit_mask) | (buf_data & bit_mask)) : cur_rd;

   always_ff @(posedge clk) begin
      if (commit) mem[buf_addr] <= (cur_wr & ~bit_mask) | (buf_data & bit_mask);
   end
endmodule

// File: rtl/b2_rd_mux.sv
module b2_rd_mux
   import b2_sram_pkg::*;
#(
   parameter int unsigned BUS_W = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [2*BUS_W-1:0] word,
   output logic [BUS_W-1:0]   dq_o,
   output logic               valid,
   output beat_e              beat
);
   logic [BUS_W-1:0] odd_hold;
   logic             odd_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_o     <= '0;
         valid    <= 1'b0;
         beat     <= BEAT_EVEN;
         odd_hold <= '0;
         odd_pend <= 1'b0;
      end else if (fire) begin
         dq_o     <= word[BUS_W-1:0];
         odd_hold <= word[2*BUS_W-1:BUS_W];
         valid    <= 1'b1;
         beat     <= BEAT_EVEN;
         odd_pend <= 1'b1;
      end else if (odd_pend) begin
         dq_o     <= odd_hold;
         valid    <= 1'b1;
         beat     <= BEAT_ODD;
         odd_pend <= 1'b0;
      end else begin
         dq_o  <= '0;
         valid <= 1'b0;
         beat  <= BEAT_EVEN;
      end
   end
endmodule

// File: rtl/b2_ddr_sram.sv
module b2_ddr_sram
   import b2_sram_pkg::*;
#(
   parameter int unsigned BUS_W  = 18,
   parameter int unsigned AW     = 5,
   parameter int unsigned RD_LAT = 4,
   localparam int unsigned LANES = BUS_W / LANE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_ld,
   input  logic             cmd_wr,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [LANES-1:0] bw_en,
   input  logic [BUS_W-1:0] dq_i,
   output logic [BUS_W-1:0] dq_o,
   output logic             dq_oe,
   output logic             rd_valid,
   output logic             rd_beat
);
   if (BUS_W % LANE_BITS != 0 || BUS_W == 0) begin : g_bad_width
      $error("BUS_W must be a non-zero multiple of the lane width");
   end
   if (RD_LAT < 2) begin : g_bad_lat
      $error("RD_LAT must be at least 2 beats");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end

   logic               cmd_acc;
   logic               wr_even_cap, wr_odd_cap;
   logic [AW-1:0]      wr_addr, rd_addr;
   logic               rd_fire;
   logic               buf_vld, commit;
   logic [AW-1:0]      buf_addr;
   logic [2*BUS_W-1:0] buf_data, rd_word;
   logic [2*LANES-1:0] buf_lanes;
   beat_e              beat_ph;

   b2_cmd_ctl #(.AW(AW), .RD_LAT(RD_LAT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_ld(cmd_ld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
      .cmd_acc(cmd_acc), .wr_even_cap(wr_even_cap), .wr_odd_cap(wr_odd_cap),
      .wr_addr(wr_addr), .rd_fire(rd_fire), .rd_addr(rd_addr)
   );

   b2_wr_gather #(.BUS_W(BUS_W), .AW(AW)) u_gather (
      .clk(clk), .rst_n(rst_n), .even_cap(wr_even_cap), .odd_cap(wr_odd_cap),
      .wr_addr(wr_addr), .dq_i(dq_i), .bw_en(bw_en), .buf_vld(buf_vld),
      .buf_addr(buf_addr), .buf_data(buf_data), .buf_lanes(buf_lanes), .commit(commit)
   );

   b2_array #(.BUS_W(BUS_W), .AW(AW)) u_array (
      .clk(clk), .commit(commit), .buf_vld(buf_vld), .buf_addr(buf_addr),
      .buf_data(buf_data), .buf_lanes(buf_lanes), .rd_addr(rd_addr), .rd_word(rd_word)
   );

   b2_rd_mux #(.BUS_W(BUS_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .fire(rd_fire), .word(rd_word),
      .dq_o(dq_o), .valid(rd_valid), .beat(beat_ph)
   );

   assign rd_beat = (beat_ph == BEAT_ODD);
   assign dq_oe   = rd_valid;
endmodule

// File: rtl/b2_sram_chk.sv
module b2_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_acc,
   input logic rd_fire,
   input logic rd_valid,
   input logic rd_beat
);
   // R6
   no_double_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_acc |=> !cmd_acc);

   // R2
   odd_follows_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_beat) |=> (rd_valid && rd_beat));

   // R8
   odd_has_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_beat) |-> ($past(rd_valid) && !$past(rd_beat)));

   // R2
   even_from_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_beat) |-> $past(rd_fire));
endmodule

bind b2_ddr_sram b2_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .rd_fire(rd_fire),
   .rd_valid(rd_valid), .rd_beat(rd_beat)
);

// File: tb/test_b2_ddr_sram.sv
module test_b2_ddr_sram;
   localparam int BW = 18;
   localparam int AWD = 5;
   localparam int NL = BW / 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_ld = 1'b0, cmd_wr = 1'b0;
   logic [AWD-1:0] cmd_addr = '0;
   logic [NL-1:0] bw_en = '0;
   logic [BW-1:0] dq_i = '0;
   logic [BW-1:0] dq_o;
   logic          dq_oe, rd_valid, rd_beat;

   int checks = 0;
   int fails = 0;
   logic [2*BW-1:0] model [1 << AWD];

   always #10 clk = ~clk;

   b2_ddr_sram #(.BUS_W(BW), .AW(AWD), .RD_LAT(4)) i_b2_ddr_sram (
      .clk(clk), .rst_n(rst_n), .cmd_ld(cmd_ld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
      .bw_en(bw_en), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
      .rd_valid(rd_valid), .rd_beat(rd_beat)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // lane-by-lane reference merge (R4)
   task automatic model_write(input int a, input logic [BW-1:0] d0, input logic [BW-1:0] d1,
                              input logic [NL-1:0] b0, input logic [NL-1:0] b1);
      logic [2*BW-1:0] nw = {d1, d0};
      logic [2*NL-1:0] en = {b1, b0};
      for (int j = 0; j < 2 * NL; j++)
         if (en[j]) model[a][j*9 +: 9] = nw[j*9 +: 9];
   endtask

   function automatic logic [63:0] beat_vec(input logic v, input logic oe, input logic ph,
                                            input logic [BW-1:0] d);
      return {41'd0, v, oe, ph, d};
   endfunction

   task automatic wr_cmd(input int a, input logic [BW-1:0] d0, input logic [BW-1:0] d1,
                         input logic [NL-1:0] b0, input logic [NL-1:0] b1);
      cmd_ld = 1'b1; cmd_wr = 1'b1; cmd_addr = AWD'(a);
      @(negedge clk);
      cmd_ld = 1'b0; dq_i = d0; bw_en = b0;
      @(negedge clk);
      dq_i = d1; bw_en = b1;
      @(negedge clk);
      dq_i = '0; bw_en = '0;
      model_write(a, d0, d1, b0, b1);
   endtask

   task automatic rd_check(input int a, input string req);
      logic [2*BW-1:0] e = model[a];
      cmd_ld = 1'b1; cmd_wr = 1'b0; cmd_addr = AWD'(a);
      @(negedge clk);
      cmd_ld = 1'b0;
      repeat (3) @(negedge clk);
      @(negedge clk);
      check(req, beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 0, e[BW-1:0]));
      @(negedge clk);
      check(req, beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 1, e[2*BW-1:BW]));
      @(negedge clk);
      check(req, {62'd0, rd_valid, dq_oe}, 64'd0);
   endtask

   task automatic t_reset();
      check("R1", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), 64'd0);
   endtask

   task automatic t_basic();
      wr_cmd(5, 18'h0AAAA, 18'h15555, 2'b11, 2'b11);
      wr_cmd(9, 18'h12345, 18'h2BCDE, 2'b11, 2'b11);
      rd_check(5, "R3");
      rd_check(9, "R5");
   endtask

   task automatic t_lanes();
      wr_cmd(5, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b10);
      rd_check(5, "R4/R5");
      wr_cmd(7, 18'h00111, 18'h00222, 2'b11, 2'b11);
      rd_check(5, "R4");
   endtask

   task automatic t_order();
      logic [2*BW-1:0] old = model[9];
      cmd_ld = 1'b1; cmd_wr = 1'b0; cmd_addr = AWD'(9);
      @(negedge clk);
      cmd_ld = 1'b0;
      @(negedge clk);
      cmd_ld = 1'b1; cmd_wr = 1'b1; cmd_addr = AWD'(9);
      @(negedge clk);
      cmd_ld = 1'b0; dq_i = 18'h01010; bw_en = 2'b11;
      @(negedge clk);
      dq_i = 18'h20202;
      @(negedge clk);
      dq_i = '0; bw_en = '0;
      check("R7", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 0, old[BW-1:0]));
      @(negedge clk);
      check("R7", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 1, old[2*BW-1:BW]));
      model_write(9, 18'h01010, 18'h20202, 2'b11, 2'b11);
      @(negedge clk);
      rd_check(9, "R5");
   endtask

   task automatic t_ignore();
      int seen = 0;
      wr_cmd(4, 18'h0F0F0, 18'h30303, 2'b11, 2'b11);
      cmd_ld = 1'b1; cmd_wr = 1'b1; cmd_addr = AWD'(4);
      @(negedge clk);
      cmd_ld = 1'b1; cmd_wr = 1'b0; cmd_addr = AWD'(4);
      dq_i = 18'h3C3C3; bw_en = 2'b11;
      @(negedge clk);
      cmd_ld = 1'b0; dq_i = 18'h05A5A;
      @(negedge clk);
      dq_i = '0; bw_en = '0;
      model_write(4, 18'h3C3C3, 18'h05A5A, 2'b11, 2'b11);
      for (int k = 0; k < 6; k++) begin
         if (rd_valid || dq_oe) seen++;
         @(negedge clk);
      end
      check("R6/R8", 64'(seen), 64'd0);
      rd_check(4, "R6");
   endtask

   task automatic t_stream();
      logic [2*BW-1:0] ea = model[5];
      logic [2*BW-1:0] eb = model[9];
      cmd_ld = 1'b1; cmd_wr = 1'b0; cmd_addr = AWD'(5);
      @(negedge clk);
      cmd_ld = 1'b0;
      @(negedge clk);
      cmd_ld = 1'b1; cmd_addr = AWD'(9);
      @(negedge clk);
      cmd_ld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R9", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 0, ea[BW-1:0]));
      @(negedge clk);
      check("R9", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 1, ea[2*BW-1:BW]));
      @(negedge clk);
      check("R9", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 0, eb[BW-1:0]));
      @(negedge clk);
      check("R9", beat_vec(rd_valid, dq_oe, rd_beat, dq_o), beat_vec(1, 1, 1, eb[2*BW-1:BW]));
      @(negedge clk);
      check("R8", {62'd0, rd_valid, dq_oe}, 64'd0);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_lanes();
      t_order();
      t_ignore();
      t_stream();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule